// File: doc/BRIEF.md
# Dual-Slope Conversion Sequencer

This block is the digital control for a dual-slope analog-to-digital converter whose counting happens in an external up-counter. A falling edge on the convert command starts a conversion. The block first sends a reset pulse to the counter. It then gates a train of counting pulses while the integrator charges from the analog input.

When the external counter wraps, its carry ends the input phase. The block then switches the integrator over to the reference and samples the input sign. It keeps pulsing until the comparator reports that the integrator has returned to zero. At that point it stops the train and drops a strobe that latches the counter into an output register.

The block has four result outputs: a polarity pair, an overrange pair, a ramp-down bit and an analog switch select. The counter's carry output also drives the overrange input. A second wrap during the reference phase therefore flags an over-scale input. A reference phase that runs past twice the input-phase pulse count is cut short and treated as overrange. In automatic mode the block starts the next conversion by itself, a programmable number of idle cycles after each end of conversion. All pulse widths and periods are counted in system clock cycles and set by parameters.

Top module: `dslope_seq`

## Requirements
- R1: In idle, a 1-to-0 transition of `conv_n` starts a conversion. From the next cycle, `ctr_rst` is high for exactly `PW` cycles, and `pulse_out` stays low during that time.
- R2: Each start clears the previous conversion's flags: `pol_pos`=1, `pol_neg`=0, `ovr`=0, `ovr_n`=1.
- R3: Once `ctr_rst` falls, the first counting pulse appears in the same cycle. Each pulse is high for `PW` cycles and the train repeats every `PER` cycles. `sel_ref` stays 0 during the input phase.
- R4: A 0-to-1 edge on `carry_in` in the input phase raises `ramp_dn` and `sel_ref` one cycle later. In that same cycle, `pol_neg` takes the value of `sign_neg` sampled at the edge (1 = negative input).
- R5: A 0-to-1 edge on `ovr_in` during the reference phase sets `ovr`=1 and `ovr_n`=0. Both stay set through the end of conversion until the next start.
- R6: When `zero_det` is high in the reference phase, the next cycle has `pulse_out`, `ramp_dn` and `sel_ref` at 0. `eoc_n` is then low for exactly `PW` cycles.
- R7: A falling edge of `conv_n` while a conversion is running is ignored.
- R8: If the reference phase reaches twice as many pulses as the input phase without `zero_det`, the conversion ends with `ovr`=1 and an end-of-conversion strobe. Exactly 2N reference pulses appear, where N is the number of input-phase pulses.
- R9: With `auto_en`=1, the idle gap after `eoc_n` returns high lasts exactly `auto_gap`+1 cycles, and then `ctr_rst` rises with no command. With `auto_en`=0, no conversion starts by itself.
- R10: `pol_pos` is always the complement of `pol_neg`, and `ovr_n` is always the complement of `ovr`.
- R11: In the input phase, `zero_det` and an `ovr_in` edge have no effect. This includes the `ovr_in` edge that arrives together with the carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| conv_n | input | 1 | Convert command, falling edge starts |
| carry_in | input | 1 | Carry from external counter |
| ovr_in | input | 1 | Overrange carry input |
| zero_det | input | 1 | Integrator back at zero |
| sign_neg | input | 1 | Sampled input sign, 1 = negative |
| auto_en | input | 1 | Enable automatic repeat |
| auto_gap | input | GAP_W | Idle cycles before automatic start, minus one |
| ctr_rst | output | 1 | Counter reset pulse |
| pulse_out | output | 1 | Gated counting pulse train |
| pol_pos | output | 1 | Positive polarity flag |
| pol_neg | output | 1 | Negative polarity flag |
| ovr | output | 1 | Overrange flag |
| ovr_n | output | 1 | Complement of overrange |
| ramp_dn | output | 1 | Reference integration in progress |
| eoc_n | output | 1 | Active-low end-of-conversion strobe |
| sel_ref | output | 1 | Analog switch: 1 = reference, 0 = input |

## Verification
The overrange carry and the zero indication can land in the same cycle of the reference phase. The bench provokes this by raising `ovr_in` and `zero_det` on the same clock. It expects the conversion to end on the next cycle with `ovr` already set, so neither event is lost to the other.

A related coincidence happens in every normal conversion: the carry and the jumpered overrange edge arrive together in the input phase. Here the bench expects the reference phase to begin while `ovr` stays 0.

// File: rtl/dslope_seq.sv
module dslope_seq #(
  parameter int PW    = 4,
  parameter int PER   = 8,
  parameter int CNT_W = 8,
  parameter int GAP_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             conv_n,
  input  logic             carry_in,
  input  logic             ovr_in,
  input  logic             zero_det,
  input  logic             sign_neg,
  input  logic             auto_en,
  input  logic [GAP_W-1:0] auto_gap,
  output logic             ctr_rst,
  output logic             pulse_out,
  output logic             pol_pos,
  output logic             pol_neg,
  output logic             ovr,
  output logic             ovr_n,
  output logic             ramp_dn,
  output logic             eoc_n,
  output logic             sel_ref
);
  localparam int PH_W = (PER > 1) ? $clog2(PER) : 1;
  localparam int RC_W = $clog2(PW + 1);

  typedef enum logic [2:0] {S_IDLE, S_RST, S_INT, S_REF, S_EOC} st_t;

  st_t              st;
  logic             conv_d, carry_d, ovr_d, armed, pol_q, ovr_q;
  logic [PH_W-1:0]  ph;
  logic [RC_W-1:0]  rc;
  logic [CNT_W-1:0] in_cnt;
  logic [CNT_W:0]   ref_cnt;
  logic [GAP_W-1:0] gap_cnt;

  wire conv_fall  = conv_d & ~conv_n;
  wire carry_rise = ~carry_d & carry_in;
  wire ovr_rise   = ~ovr_d & ovr_in;
  wire running    = (st == S_INT) || (st == S_REF);
  wire ph_wrap    = ph == PH_W'(PER - 1);
  wire rc_done    = rc == RC_W'(PW - 1);
  wire tmo        = (st == S_REF) && (ph == '0) && (ref_cnt == {in_cnt, 1'b0});
  wire auto_fire  = armed && auto_en && (gap_cnt == auto_gap);
  wire start      = (st == S_IDLE) && (conv_fall || auto_fire);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      conv_d  <= 1'b1;
      carry_d <= 1'b0;
      ovr_d   <= 1'b0;
      armed   <= 1'b0;
      pol_q   <= 1'b0;
      ovr_q   <= 1'b0;
      ph      <= '0;
      rc      <= '0;
      in_cnt  <= '0;
      ref_cnt <= '0;
      gap_cnt <= '0;
    end else begin
      conv_d  <= conv_n;
      carry_d <= carry_in;
      ovr_d   <= ovr_in;
      case (st)
        S_IDLE: begin
          if (start) begin
            st      <= S_RST;
            rc      <= '0;
            pol_q   <= 1'b0;
            ovr_q   <= 1'b0;
            armed   <= 1'b0;
            gap_cnt <= '0;
            in_cnt  <= '0;
          end else if (armed && auto_en) begin
            gap_cnt <= gap_cnt + 1'b1;
          end else begin
            armed   <= 1'b0;
            gap_cnt <= '0;
          end
        end
        S_RST: begin
          rc <= rc + 1'b1;
          if (rc_done) begin
            st <= S_INT;
            ph <= '0;
          end
        end
        S_INT: begin
          ph <= ph_wrap ? '0 : ph + 1'b1;
          if (ph == '0 && in_cnt != '1) in_cnt <= in_cnt + 1'b1;
          if (carry_rise) begin
            st      <= S_REF;
            ph      <= '0;
            ref_cnt <= '0;
            pol_q   <= sign_neg;
          end
        end
        S_REF: begin
          ph <= ph_wrap ? '0 : ph + 1'b1;
          if (ph == '0) ref_cnt <= ref_cnt + 1'b1;
          if (ovr_rise) ovr_q <= 1'b1;
          if (zero_det) begin
            st <= S_EOC;
            rc <= '0;
          end else if (tmo) begin
            st    <= S_EOC;
            rc    <= '0;
            ovr_q <= 1'b1;
          end
        end
        S_EOC: begin
          rc <= rc + 1'b1;
          if (rc_done) begin
            st      <= S_IDLE;
            armed   <= auto_en;
            gap_cnt <= '0;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign ctr_rst   = st == S_RST;
  assign pulse_out = running && (32'(ph) < PW) && !tmo;
  assign ramp_dn   = st == S_REF;
  assign sel_ref   = st == S_REF;
  assign eoc_n     = st != S_EOC;
  assign pol_neg   = pol_q;
  assign pol_pos   = ~pol_q;
  assign ovr       = ovr_q;
  assign ovr_n     = ~ovr_q;
endmodule

// File: rtl/dslope_seq_chk.sv
module dslope_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic ctr_rst,
  input logic pulse_out,
  input logic pol_pos,
  input logic pol_neg,
  input logic ovr,
  input logic ovr_n,
  input logic ramp_dn,
  input logic eoc_n,
  input logic sel_ref
);
  AST_FLAG_PAIRS: assert property (@(posedge clk) disable iff (!rst_n) (pol_pos != pol_neg) && (ovr != ovr_n)); // R10
  AST_RST_QUIET: assert property (@(posedge clk) disable iff (!rst_n) ctr_rst |-> (!pulse_out && eoc_n && !ramp_dn && !sel_ref)); // R1
  AST_POL_AT_REF: assert property (@(posedge clk) disable iff (!rst_n) $rose(pol_neg) |-> $rose(ramp_dn)); // R4
  AST_OVR_HOLD: assert property (@(posedge clk) disable iff (!rst_n) ovr |=> (ovr || ctr_rst)); // R5
  AST_OVR_IN_REF: assert property (@(posedge clk) disable iff (!rst_n) $rose(ovr) |-> (ramp_dn || !eoc_n)); // R8
  AST_EOC_QUIET: assert property (@(posedge clk) disable iff (!rst_n) !eoc_n |-> (!pulse_out && !ramp_dn && !sel_ref)); // R6
  AST_EOC_AFTER_REF: assert property (@(posedge clk) disable iff (!rst_n) $fell(eoc_n) |-> $past(ramp_dn)); // R6
endmodule

bind dslope_seq dslope_seq_chk u_chk (.*);

// File: tb/test_dslope_seq.sv
`timescale 1ns/1ps
module test_dslope_seq;
  localparam int PW  = 4;
  localparam int PER = 8;
  localparam int GAP = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic conv_n = 1'b1, carry_in = 1'b0, ovr_in = 1'b0, zero_det = 1'b0, sign_neg = 1'b0, auto_en = 1'b0;
  logic [7:0] auto_gap = 8'd0;
  logic ctr_rst, pulse_out, pol_pos, pol_neg, ovr, ovr_n, ramp_dn, eoc_n, sel_ref;
  int total = 0;
  int bad = 0;

  always #4 clk = ~clk;

  dslope_seq #(.PW(PW), .PER(PER), .CNT_W(8), .GAP_W(8)) i_dslope_seq (
    .clk(clk), .rst_n(rst_n), .conv_n(conv_n), .carry_in(carry_in), .ovr_in(ovr_in),
    .zero_det(zero_det), .sign_neg(sign_neg), .auto_en(auto_en), .auto_gap(auto_gap),
    .ctr_rst(ctr_rst), .pulse_out(pulse_out), .pol_pos(pol_pos), .pol_neg(pol_neg),
    .ovr(ovr), .ovr_n(ovr_n), .ramp_dn(ramp_dn), .eoc_n(eoc_n), .sel_ref(sel_ref));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic tick;
    @(negedge clk);
  endtask

  task automatic pulses(input int n);
    int c;
    int g;
    logic p;
    c = 0; g = 0; p = pulse_out;
    while (c < n && g < 2000) begin
      tick;
      if (pulse_out && !p) c++;
      p = pulse_out;
      g++;
    end
  endtask

  task automatic begin_conv;
    int r;
    int g;
    conv_n = 1'b0;
    tick;
    conv_n = 1'b1;
    chk(ctr_rst == 1'b1, "R1 ctr_rst after command", ctr_rst, 1);
    chk(pol_pos == 1'b1 && pol_neg == 1'b0, "R2 polarity cleared", pol_neg, 0);
    chk(ovr == 1'b0 && ovr_n == 1'b1, "R2 overrange cleared", ovr, 0);
    r = 1; g = 0;
    forever begin
      tick;
      g++;
      if (!ctr_rst || g > 100) break;
      if (pulse_out) chk(0, "R1 pulse during reset", 1, 0);
      r++;
    end
    chk(r == PW, "R1 reset width", r, PW);
    chk(pulse_out == 1'b1 && sel_ref == 1'b0, "R3 first pulse after reset", pulse_out, 1);
  endtask

  task automatic enter_ref(input bit neg);
    sign_neg = neg;
    carry_in = 1'b1;
    ovr_in = 1'b1;
    tick;
    carry_in = 1'b0;
    ovr_in = 1'b0;
    chk(ramp_dn == 1'b1 && sel_ref == 1'b1, "R4 reference phase entered", ramp_dn, 1);
    chk(pol_neg == neg, "R4 polarity sampled", pol_neg, neg);
    chk(ovr == 1'b0, "R11 overrange edge with carry ignored", ovr, 0);
  endtask

  task automatic wait_eoc_end(output int e);
    int g;
    e = 1; g = 0;
    forever begin
      tick;
      g++;
      if (eoc_n || g > 100) break;
      e++;
    end
  endtask

  task automatic finish_conv;
    int e;
    zero_det = 1'b1;
    tick;
    zero_det = 1'b0;
    chk(eoc_n == 1'b0 && pulse_out == 1'b0, "R6 strobe and train stop", eoc_n, 0);
    chk(ramp_dn == 1'b0 && sel_ref == 1'b0, "R6 ramp down cleared", ramp_dn, 0);
    wait_eoc_end(e);
    chk(e == PW, "R6 strobe width", e, PW);
  endtask

  task automatic t_reset;
    tick;
    chk(ctr_rst == 1'b0 && pulse_out == 1'b0 && eoc_n == 1'b1, "R1 idle after reset", ctr_rst, 0);
    chk(pol_pos == 1'b1 && pol_neg == 1'b0 && ovr == 1'b0 && ovr_n == 1'b1, "R10 reset flags", ovr_n, 1);
  endtask

  task automatic t_positive;
    int hi;
    int lo;
    begin_conv;
    hi = 1;
    while (pulse_out && hi < 100) begin tick; if (pulse_out) hi++; end
    chk(hi == PW, "R3 pulse width", hi, PW);
    lo = 1;
    while (lo < 100) begin tick; if (pulse_out) break; lo++; end
    chk(lo == PER - PW, "R3 pulse gap", lo, PER - PW);
    zero_det = 1'b1;
    tick;
    zero_det = 1'b0;
    chk(eoc_n == 1'b1 && ramp_dn == 1'b0 && sel_ref == 1'b0, "R11 zero in input phase ignored", eoc_n, 1);
    pulses(3);
    enter_ref(1'b0);
    chk(pol_pos == 1'b1, "R4 positive polarity kept", pol_pos, 1);
    pulses(2);
    finish_conv;
    chk(ovr == 1'b0, "R5 no overrange", ovr, 0);
  endtask

  task automatic t_negative_ovr;
    begin_conv;
    pulses(3);
    enter_ref(1'b1);
    chk(pol_pos == 1'b0, "R4 positive flag drops", pol_pos, 0);
    pulses(1);
    ovr_in = 1'b1;
    tick;
    ovr_in = 1'b0;
    chk(ovr == 1'b1 && ovr_n == 1'b0, "R5 overrange set", ovr, 1);
    conv_n = 1'b0;
    tick;
    conv_n = 1'b1;
    chk(ctr_rst == 1'b0 && ramp_dn == 1'b1, "R7 command while busy ignored", ctr_rst, 0);
    tick;
    chk(ctr_rst == 1'b0 && ramp_dn == 1'b1, "R7 still in reference phase", ramp_dn, 1);
    pulses(2);
    chk(ovr == 1'b1, "R5 overrange held", ovr, 1);
    finish_conv;
    tick;
    chk(ovr == 1'b1 && pol_neg == 1'b1, "R5 flags held after strobe", ovr, 1);
  endtask

  task automatic t_coincide;
    int e;
    begin_conv;
    pulses(2);
    enter_ref(1'b0);
    pulses(1);
    ovr_in = 1'b1;
    zero_det = 1'b1;
    tick;
    ovr_in = 1'b0;
    zero_det = 1'b0;
    chk(eoc_n == 1'b0, "R6 end on coincident zero", eoc_n, 0);
    chk(ovr == 1'b1, "R5 coincident overrange kept", ovr, 1);
    wait_eoc_end(e);
  endtask

  task automatic t_timeout;
    int c;
    int g;
    int e;
    logic p;
    begin_conv;
    pulses(2);
    enter_ref(1'b0);
    c = pulse_out ? 1 : 0; p = pulse_out; g = 0;
    while (eoc_n && g < 2000) begin
      tick;
      if (pulse_out && !p) c++;
      p = pulse_out;
      g++;
    end
    chk(eoc_n == 1'b0, "R8 timeout strobe", eoc_n, 0);
    chk(c == 6, "R8 reference pulse count", c, 6);
    chk(ovr == 1'b1, "R8 timeout overrange", ovr, 1);
    wait_eoc_end(e);
  endtask

  task automatic t_auto;
    int idle;
    int seen;
    auto_gap = 8'(GAP);
    auto_en = 1'b1;
    begin_conv;
    enter_ref(1'b0);
    pulses(1);
    finish_conv;
    idle = 0;
    while (!ctr_rst && idle < 200) begin idle++; tick; end
    chk(idle == GAP + 1, "R9 automatic restart gap", idle, GAP + 1);
    auto_en = 1'b0;
    while (ctr_rst) tick;
    pulses(1);
    enter_ref(1'b1);
    pulses(1);
    finish_conv;
    seen = 0;
    for (int i = 0; i < 30; i++) begin
      tick;
      if (ctr_rst) seen++;
    end
    chk(seen == 0, "R9 no restart when disabled", seen, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog R1 act=hung exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) tick;
    rst_n = 1'b1;
    t_reset;
    t_positive;
    t_negative_ovr;
    t_coincide;
    t_timeout;
    t_auto;
    repeat (3) tick;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule